// File: doc/BRIEF.md
# Round Key Generator with Parity Prediction

This block forms the per-round key of a 128-bit lightweight block cipher. A fixed 128-bit key, viewed as sixteen 8-bit cells, is combined with one of nineteen round constants chosen by a round index. Each constant holds a single bit per cell, and that bit is XORed into bit 0 of the matching key cell only. The result is registered and presented one cycle later, together with a valid strobe.

The block also predicts the parity signature of the round key. It takes the prediction from the parity of the key and a constant parity that is computed once, at elaboration, from the constant table. It does not use the round key for this. Because a constant only ever flips bit 0 of a cell, each predicted parity is either the key's parity unchanged or its inverse. A second path computes the real parity of the produced round key and raises an error flag when the two disagree.

A mode input selects what is compared. Mode 0 compares sixteen per-cell parities and ORs the mismatches. Mode 1 compares one parity taken over the whole state. A test-only fault mask is XORed into the round key after it is generated, so injected errors can be observed at the flag.

Top module: `rkg_round_key_gen`

## Requirements
- R1: Outputs are registered. `out_valid` equals `in_valid` from the previous clock edge. While `rst_n` is low, every output is 0.
- R2: Cell j is `in_key[8j+7:8j]`. Constant bit j of round r is bit j of that round's 16-bit table entry. `out_rkey = in_key ^ F ^ in_fault`, where F sets bit 8j for every constant bit j that is 1. No other bit of the key is changed by the constant.
- R3: A round index from 19 to 31 selects an all-zero constant.
- R4: `out_cpred[j]` is the XOR of the 8 bits of key cell j with constant bit j.
- R5: `out_wpred` is the XOR of all 128 key bits with the parity of the selected constant. In the default table, rounds 0 and 18 have even-weight constants, which leave the key parity intact. Round 14 has an odd-weight constant, which inverts it.
- R6: `out_cact[j]` is the XOR of the 8 bits of round-key cell j. `out_wact` is the XOR of all 128 round-key bits.
- R7: With `in_mode`=0 (per-cell), `out_err` is the OR of `out_cpred ^ out_cact`. With `in_mode`=1 (whole-state), `out_err` is `out_wpred ^ out_wact`.
- R8: With `in_fault` all zero, `out_err` is 0 for every round index and both modes.
- R9: Any fault mask with exactly one bit set gives `out_err`=1 in both modes.
- R10: Two fault bits in different cells give `out_err`=1 in mode 0 and 0 in mode 1. Two fault bits in the same cell give 0 in both modes.
- R11: While `in_valid` is low, the data outputs keep their last values and input changes have no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture request for the inputs below |
| in_key | input | 128 | Cipher key, sixteen 8-bit cells |
| in_round | input | 5 | Round index, 0 to 18 in use |
| in_mode | input | 1 | 0 = per-cell check, 1 = whole-state check |
| in_fault | input | 128 | Test fault mask XORed into the round key |
| out_valid | output | 1 | Outputs hold a fresh result |
| out_rkey | output | 128 | Round key |
| out_cpred | output | 16 | Predicted per-cell parities |
| out_cact | output | 16 | Actual per-cell parities |
| out_wpred | output | 1 | Predicted whole-state parity |
| out_wact | output | 1 | Actual whole-state parity |
| out_err | output | 1 | Mismatch flag for the selected mode |

## Verification
Clean keys are run across all nineteen rounds and two out-of-range indices. This shows that each constant lands on bit 0 of the correct cells, and that even-weight and odd-weight constants are told apart in the whole-state prediction. Single-bit faults are swept over all 128 positions in both modes, which shows that every bit position is covered by both checks. Pairs of faults are then placed in two different cells and within one cell. These separate the per-cell check from the whole-state check and expose the blind spot that both share.

// File: rtl/rkg_pkg.sv
package rkg_pkg;

    localparam int RKG_ROUNDS = 19;
    localparam int RKG_CELLS  = 16;
    localparam int RKG_CELL_W = 8;

    typedef enum logic {
        CHK_PER_CELL = 1'b0,
        CHK_WHOLE    = 1'b1
    } chk_mode_e;

    // Round r occupies bits [16r+15:16r]; bit j touches cell j.
    // Listed from round 18 down to round 0.
    localparam logic [RKG_ROUNDS*RKG_CELLS-1:0] RKG_RC_DEFAULT = {
        16'h63A5, 16'hD491, 16'h0B6E, 16'hF203, 16'h27D9,
        16'hB615, 16'h4CB0, 16'h81F9, 16'hE472, 16'h3A1D,
        16'h5587, 16'hC06B, 16'h2E5C, 16'h9931, 16'h0F4A,
        16'h6DE1, 16'hA026, 16'h78C2, 16'h15B3
    };

endpackage

// File: rtl/rkg_const_sel.sv
module rkg_const_sel #(
    parameter int NR = 19,
    parameter int C  = 16,
    parameter int IW = 5,
    parameter logic [NR*C-1:0] TABLE = '0
) (
    input  logic [IW-1:0] idx,
    output logic [C-1:0]  rc,
    output logic          rc_par
);

    // Constant parities fixed at elaboration.
    logic [NR-1:0] par_tab;

    generate
        for (genvar r = 0; r < NR; r++) begin : g_par
            assign par_tab[r] = ^TABLE[r*C +: C];
        end
    endgenerate

    always_comb begin
        rc     = '0;
        rc_par = 1'b0;
        for (int r = 0; r < NR; r++) begin
            if (idx == IW'(r)) begin
                rc     = TABLE[r*C +: C];
                rc_par = par_tab[r];
            end
        end
    end

endmodule

// File: rtl/rkg_key_mix.sv
module rkg_key_mix #(
    parameter int C  = 16,
    parameter int CW = 8
) (
    input  logic [C*CW-1:0] key,
    input  logic [C-1:0]    rc,
    input  logic [C*CW-1:0] fault,
    output logic [C*CW-1:0] rk
);

    generate
        for (genvar j = 0; j < C; j++) begin : g_cell
            assign rk[j*CW +: CW] = key[j*CW +: CW]
                                  ^ {{(CW-1){1'b0}}, rc[j]}
                                  ^ fault[j*CW +: CW];
        end
    endgenerate

endmodule

// File: rtl/rkg_sig_predict.sv
module rkg_sig_predict #(
    parameter int C  = 16,
    parameter int CW = 8
) (
    input  logic [C*CW-1:0] key,
    input  logic [C-1:0]    rc,
    input  logic            rc_par,
    output logic [C-1:0]    cpred,
    output logic            wpred
);

    // Prediction uses only the key and the constant, never the round key.
    generate
        for (genvar j = 0; j < C; j++) begin : g_cell
            assign cpred[j] = (^key[j*CW +: CW]) ^ rc[j];
        end
    endgenerate

    assign wpred = (^key) ^ rc_par;

endmodule

// File: rtl/rkg_sig_check.sv
module rkg_sig_check #(
    parameter int C  = 16,
    parameter int CW = 8
) (
    input  logic [C*CW-1:0]        rk,
    input  logic [C-1:0]           cpred,
    input  logic                   wpred,
    input  rkg_pkg::chk_mode_e     mode,
    output logic [C-1:0]           cact,
    output logic                   wact,
    output logic                   err
);

    generate
        for (genvar j = 0; j < C; j++) begin : g_cell
            assign cact[j] = ^rk[j*CW +: CW];
        end
    endgenerate

    assign wact = ^rk;

    always_comb begin
        if (mode == rkg_pkg::CHK_WHOLE) err = wact ^ wpred;
        else                            err = |(cact ^ cpred);
    end

endmodule

// File: rtl/rkg_round_key_gen.sv
module rkg_round_key_gen #(
    parameter int NUM_ROUNDS = rkg_pkg::RKG_ROUNDS,
    parameter int NUM_CELLS  = rkg_pkg::RKG_CELLS,
    parameter int CELL_W     = rkg_pkg::RKG_CELL_W,
    parameter logic [NUM_ROUNDS*NUM_CELLS-1:0] RC_TABLE = rkg_pkg::RKG_RC_DEFAULT,
    localparam int KEY_W = NUM_CELLS * CELL_W,
    localparam int IDX_W = $clog2(NUM_ROUNDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [KEY_W-1:0]     in_key,
    input  logic [IDX_W-1:0]     in_round,
    input  logic                 in_mode,
    input  logic [KEY_W-1:0]     in_fault,
    output logic                 out_valid,
    output logic [KEY_W-1:0]     out_rkey,
    output logic [NUM_CELLS-1:0] out_cpred,
    output logic [NUM_CELLS-1:0] out_cact,
    output logic                 out_wpred,
    output logic                 out_wact,
    output logic                 out_err
);

    typedef struct packed {
        logic                 vld;
        logic [KEY_W-1:0]     rk;
        logic [NUM_CELLS-1:0] cpred;
        logic [NUM_CELLS-1:0] cact;
        logic                 wpred;
        logic                 wact;
        logic                 err;
    } st_t;

    st_t st_d, st_q;

    logic [NUM_CELLS-1:0] rc_sel;
    logic                 rc_par;
    logic [KEY_W-1:0]     rk_c;
    logic [NUM_CELLS-1:0] cpred_c, cact_c;
    logic                 wpred_c, wact_c, err_c;
    rkg_pkg::chk_mode_e   mode_c;

    assign mode_c = rkg_pkg::chk_mode_e'(in_mode);

    rkg_const_sel #(
        .NR(NUM_ROUNDS), .C(NUM_CELLS), .IW(IDX_W), .TABLE(RC_TABLE)
    ) u_const (
        .idx(in_round), .rc(rc_sel), .rc_par(rc_par)
    );

    rkg_key_mix #(.C(NUM_CELLS), .CW(CELL_W)) u_mix (
        .key(in_key), .rc(rc_sel), .fault(in_fault), .rk(rk_c)
    );

    rkg_sig_predict #(.C(NUM_CELLS), .CW(CELL_W)) u_pred (
        .key(in_key), .rc(rc_sel), .rc_par(rc_par),
        .cpred(cpred_c), .wpred(wpred_c)
    );

    rkg_sig_check #(.C(NUM_CELLS), .CW(CELL_W)) u_chk (
        .rk(rk_c), .cpred(cpred_c), .wpred(wpred_c), .mode(mode_c),
        .cact(cact_c), .wact(wact_c), .err(err_c)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.rk    = rk_c;
            st_d.cpred = cpred_c;
            st_d.cact  = cact_c;
            st_d.wpred = wpred_c;
            st_d.wact  = wact_c;
            st_d.err   = err_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_rkey  = st_q.rk;
    assign out_cpred = st_q.cpred;
    assign out_cact  = st_q.cact;
    assign out_wpred = st_q.wpred;
    assign out_wact  = st_q.wact;
    assign out_err   = st_q.err;

endmodule

// File: rtl/rkg_round_key_gen_chk.sv
module rkg_round_key_gen_chk #(
    parameter int KEY_W  = 128,
    parameter int CELLS  = 16,
    parameter int CELL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [KEY_W-1:0] in_key,
    input logic [KEY_W-1:0] in_fault,
    input logic             out_valid,
    input logic [KEY_W-1:0] out_rkey,
    input logic [CELLS-1:0] out_cpred,
    input logic [CELLS-1:0] out_cact,
    input logic             out_err
);

    function automatic logic [KEY_W-1:0] lsb_mask_f();
        logic [KEY_W-1:0] m = '0;
        for (int i = 0; i < KEY_W; i += CELL_W) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [KEY_W-1:0] LSB_MASK = lsb_mask_f();

    p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_lsb_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (((out_rkey ^ $past(in_key ^ in_fault)) & ~LSB_MASK) == '0));

    p_cell_agree_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fault == '0) |=> (out_cpred == out_cact));

    p_no_false_alarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_fault == '0) |=> !out_err);

    p_single_flip_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && $countones(in_fault) == 1) |=> out_err);

    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_rkey) && $stable(out_err));

endmodule

bind rkg_round_key_gen rkg_round_key_gen_chk #(
    .KEY_W(KEY_W), .CELLS(NUM_CELLS), .CELL_W(CELL_W)
) u_rkg_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_key(in_key),
    .in_fault(in_fault), .out_valid(out_valid), .out_rkey(out_rkey),
    .out_cpred(out_cpred), .out_cact(out_cact), .out_err(out_err)
);

// File: tb/rkg_round_key_gen_tb_top.sv
`timescale 1ns/1ps
module rkg_round_key_gen_tb_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [127:0] in_key;
    logic [4:0]   in_round;
    logic         in_mode;
    logic [127:0] in_fault;
    logic         out_valid;
    logic [127:0] out_rkey;
    logic [15:0]  out_cpred, out_cact;
    logic         out_wpred, out_wact, out_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    rkg_round_key_gen dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_key(in_key),
        .in_round(in_round), .in_mode(in_mode), .in_fault(in_fault),
        .out_valid(out_valid), .out_rkey(out_rkey), .out_cpred(out_cpred),
        .out_cact(out_cact), .out_wpred(out_wpred), .out_wact(out_wact),
        .out_err(out_err)
    );

    // Bench copy of the constants, round 0 first.
    localparam logic [15:0] BT [19] = '{
        16'h15B3, 16'h78C2, 16'hA026, 16'h6DE1, 16'h0F4A, 16'h9931, 16'h2E5C,
        16'hC06B, 16'h5587, 16'h3A1D, 16'hE472, 16'h81F9, 16'h4CB0, 16'hB615,
        16'h27D9, 16'hF203, 16'h0B6E, 16'hD491, 16'h63A5
    };

    typedef struct packed {
        logic [127:0] key;
        logic [4:0]   idx;
        logic         mode;
        logic [127:0] fault;
        logic         err;
    } vec_t;

    localparam logic [127:0] KA = 128'h0123456789ABCDEFFEDCBA9876543210;
    localparam logic [127:0] KB = {128{1'b1}};

    localparam vec_t VT [10] = '{
        '{KA, 5'd0,  1'b0, 128'h0, 1'b0},
        '{KA, 5'd14, 1'b1, 128'h0, 1'b0},
        '{KB, 5'd18, 1'b1, 128'h0, 1'b0},
        '{KA, 5'd5,  1'b0, 128'h1, 1'b1},
        '{KA, 5'd7,  1'b1, 128'h1 << 127, 1'b1},
        '{KA, 5'd9,  1'b0, 128'h01000001, 1'b1},
        '{KA, 5'd9,  1'b1, 128'h01000001, 1'b0},
        '{KA, 5'd3,  1'b0, 128'h3, 1'b0},
        '{KA, 5'd25, 1'b0, 128'h0, 1'b0},
        '{KB, 5'd31, 1'b1, 128'h80, 1'b1}
    };

    function automatic logic [15:0] rc_of(input logic [4:0] r);
        return (r < 5'd19) ? BT[r] : 16'h0;
    endfunction

    function automatic logic [127:0] exp_rk(input logic [127:0] k,
                                            input logic [4:0] r,
                                            input logic [127:0] f);
        logic [127:0] v = k ^ f;
        logic [15:0]  c = rc_of(r);
        for (int j = 0; j < 16; j++) v[8*j] = v[8*j] ^ c[j];
        return v;
    endfunction

    function automatic logic [15:0] cell_par(input logic [127:0] v);
        logic [15:0] p;
        for (int j = 0; j < 16; j++) p[j] = ^v[8*j +: 8];
        return p;
    endfunction

    task automatic chk(input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [127:0] k, input logic [4:0] r,
                         input logic m, input logic [127:0] f);
        in_valid = 1'b1; in_key = k; in_round = r; in_mode = m; in_fault = f;
    endtask

    // Full check of one result, called one negedge after drive.
    task automatic check_all(input logic [127:0] k, input logic [4:0] r,
                             input logic [127:0] f, input logic e);
        logic [127:0] rk = exp_rk(k, r, f);
        logic [15:0]  c  = rc_of(r);
        chk("R1 valid",   {127'b0, out_valid}, 128'd1);
        chk("R2/R3 rkey", out_rkey, rk);
        chk("R4 cpred",   {112'b0, out_cpred}, {112'b0, cell_par(k) ^ c});
        chk("R5 wpred",   {127'b0, out_wpred}, {127'b0, (^k) ^ (^c)});
        chk("R6 cact",    {112'b0, out_cact},  {112'b0, cell_par(rk)});
        chk("R6 wact",    {127'b0, out_wact},  {127'b0, ^rk});
        chk("R7/R10 err", {127'b0, out_err},   {127'b0, e});
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] hold_rk;
        rst_n = 1'b0; in_valid = 1'b0; in_key = '0; in_round = '0;
        in_mode = 1'b0; in_fault = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset valid", {127'b0, out_valid}, 128'd0);
        chk("R1 reset rkey",  out_rkey, 128'd0);
        chk("R1 reset err",   {127'b0, out_err}, 128'd0);
        chk("R1 reset sigs",  {94'b0, out_cpred, out_cact, out_wpred, out_wact}, 128'd0);
        rst_n = 1'b1;

        // Vector table walk (R2, R3, R7, R10)
        foreach (VT[i]) begin
            drive(VT[i].key, VT[i].idx, VT[i].mode, VT[i].fault);
            @(negedge clk);
            check_all(VT[i].key, VT[i].idx, VT[i].fault, VT[i].err);
        end

        // R11: inputs ignored while in_valid is low
        hold_rk = out_rkey;
        in_valid = 1'b0; in_key = ~in_key; in_fault = 128'hFF; in_round = 5'd2;
        @(negedge clk);
        chk("R11 hold rkey",  out_rkey, hold_rk);
        chk("R11 hold err",   {127'b0, out_err}, 128'd1);
        chk("R1 valid low",   {127'b0, out_valid}, 128'd0);

        // R5/R8: clean sweep over every round, both modes
        for (int r = 0; r < 19; r++) begin
            for (int m = 0; m < 2; m++) begin
                drive(KA, 5'(r), m[0], 128'h0);
                @(negedge clk);
                check_all(KA, 5'(r), 128'h0, 1'b0);
                if (r == 0 || r == 18)
                    chk("R5 intact", {127'b0, out_wpred}, {127'b0, ^KA});
                if (r == 14)
                    chk("R5 inverted", {127'b0, out_wpred}, {127'b0, ~(^KA)});
            end
        end

        // R9: every single-bit fault, both modes
        for (int b = 0; b < 128; b++) begin
            for (int m = 0; m < 2; m++) begin
                drive(KB ^ KA, 5'(b % 19), m[0], 128'h1 << b);
                @(negedge clk);
                chk("R9 single flip err", {127'b0, out_err}, 128'd1);
            end
        end

        // R10: same-cell pair in whole mode, cross-cell pair on high cells
        drive(KA, 5'd11, 1'b1, 128'h18);
        @(negedge clk);
        check_all(KA, 5'd11, 128'h18, 1'b0);
        drive(KA, 5'd11, 1'b0, (128'h1 << 120) | (128'h1 << 64));
        @(negedge clk);
        check_all(KA, 5'd11, (128'h1 << 120) | (128'h1 << 64), 1'b1);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule